// File: doc/BRIEF.md
# Out-of-Frame Declaration Monitor

This block sits behind a receive framer and turns per-bit framing check results into a single out-of-frame verdict. In DS3 operation it gets two kinds of check results: one for each F framing bit and one for each M-frame's M-bit positions. In E3 operation it gets one check result for each frame alignment word. Each check result is a one-cycle strobe with an error flag. When a loss criterion is met, the block raises an out-of-frame level. In the same cycle it issues a one-clock request that starts the reframe search.

The search logic reports success on a reframe-complete input. That input drops the out-of-frame level and empties every error history, so monitoring restarts from a clean slate. The `e3_mode` input selects which strobes count. Strobes that belong to the other line format are discarded.

Top module: `oof_monitor`

## Requirements
- R1: With `e3_mode`=0, `oof` is declared once at least 3 of the most recent 16 F-bit results (one per `fbit_stb`) carry `fbit_err`=1. The window slides: a result older than the last 16 strobes no longer counts.
- R2: With `e3_mode`=0, `oof` is declared once at least 2 of the most recent 3 M-frame results (one per `mframe_stb`) carry `mframe_err`=1.
- R3: With `e3_mode`=1, `oof` is declared on the 4th consecutive `fas_stb` with `fas_err`=1. A strobe with `fas_err`=0 restarts the run at zero.
- R4: `oof` and `reframe_req` both rise on the clock edge that samples the deciding strobe. `reframe_req` is high only in the first cycle of an `oof` episode, for exactly one clock.
- R5: Once set, `oof` stays high until `reframe_done`. Further errors while it is high produce no new `reframe_req`.
- R6: `reframe_done`=1 clears `oof` and all error histories on the next edge. It takes priority over any strobe in the same cycle, and that strobe is discarded.
- R7: Strobes of the inactive format are ignored and leave `oof` at 0. In DS3 mode that means `fas_stb`. In E3 mode it means `fbit_stb` and `mframe_stb`.
- R8: While `rst_n`=0 and after its release, `oof`=0, `reframe_req`=0 and all histories are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| e3_mode | input | 1 | 1 selects E3 criteria, 0 selects DS3 criteria |
| fbit_stb | input | 1 | One F framing bit has been checked |
| fbit_err | input | 1 | That F bit was wrong |
| mframe_stb | input | 1 | One M-frame's M-bits have been checked |
| mframe_err | input | 1 | That M-frame had an M-bit error |
| fas_stb | input | 1 | One E3 alignment word has been checked |
| fas_err | input | 1 | That alignment word was wrong |
| reframe_done | input | 1 | Search has found frame again; clears the condition |
| oof | output | 1 | Out-of-frame level |
| reframe_req | output | 1 | One-clock pulse that starts a reframe |

## Verification
Two things can land on the same clock edge: the search reporting success on `reframe_done`, and a fresh error strobe that would otherwise advance a history. The bench first builds up two F-bit errors. It then drives a third erroneous F strobe together with `reframe_done`. `oof` must read 0 afterwards, and exactly three further F errors must be needed to declare again. Needing three proves that both the history and the colliding strobe were discarded.

// File: rtl/oof_monitor.sv
module oof_monitor #(
  parameter int FWIN  = 16,
  parameter int FTHR  = 3,
  parameter int MWIN  = 3,
  parameter int MTHR  = 2,
  parameter int E3RUN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic e3_mode,
  input  logic fbit_stb,
  input  logic fbit_err,
  input  logic mframe_stb,
  input  logic mframe_err,
  input  logic fas_stb,
  input  logic fas_err,
  input  logic reframe_done,
  output logic oof,
  output logic reframe_req
);
  localparam int CW = $clog2(E3RUN + 1);
  localparam logic [CW-1:0] RUN_TOP = E3RUN[CW-1:0];

  logic [FWIN-1:0] fh;
  logic [MWIN-1:0] mh;
  logic [CW-1:0]   run;

  wire f_go = ~e3_mode & fbit_stb;
  wire m_go = ~e3_mode & mframe_stb;
  wire e_go =  e3_mode & fas_stb;

  wire [FWIN-1:0] fh_nx  = {fh[FWIN-2:0], fbit_err};
  wire [MWIN-1:0] mh_nx  = {mh[MWIN-2:0], mframe_err};
  wire [CW-1:0]   run_nx = !fas_err ? '0 : (run == RUN_TOP) ? run : run + 1'b1;

  wire f_hit = f_go && ($countones(fh_nx) >= FTHR);
  wire m_hit = m_go && ($countones(mh_nx) >= MTHR);
  wire e_hit = e_go && (run_nx == RUN_TOP);
  wire hit   = f_hit | m_hit | e_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || reframe_done) begin
      fh          <= '0;
      mh          <= '0;
      run         <= '0;
      oof         <= 1'b0;
      reframe_req <= 1'b0;
    end else begin
      reframe_req <= hit & ~oof;
      if (hit)  oof <= 1'b1;
      if (f_go) fh  <= fh_nx;
      if (m_go) mh  <= mh_nx;
      if (e_go) run <= run_nx;
    end
  end
endmodule

module oof_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic e3_mode,
  input logic fbit_stb,
  input logic mframe_stb,
  input logic fas_stb,
  input logic reframe_done,
  input logic oof,
  input logic reframe_req
);
  p_req_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oof) |-> reframe_req);
  p_req_needs_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_req |-> $rose(oof));
  p_req_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_req |=> !reframe_req);
  p_oof_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (oof && !reframe_done) |=> oof);
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reframe_done |=> (!oof && !reframe_req));
  p_ds3_fas_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!e3_mode && !fbit_stb && !mframe_stb && !oof) |=> !oof);
  p_e3_fm_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (e3_mode && !fas_stb && !oof) |=> !oof);
endmodule

bind oof_monitor oof_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .e3_mode(e3_mode), .fbit_stb(fbit_stb),
  .mframe_stb(mframe_stb), .fas_stb(fas_stb), .reframe_done(reframe_done),
  .oof(oof), .reframe_req(reframe_req)
);

// File: tb/oof_monitor_tb.sv
module oof_monitor_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic e3_mode = 1'b0;
  logic fbit_stb = 1'b0, fbit_err = 1'b0;
  logic mframe_stb = 1'b0, mframe_err = 1'b0;
  logic fas_stb = 1'b0, fas_err = 1'b0;
  logic reframe_done = 1'b0;
  logic oof, reframe_req;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  oof_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .e3_mode(e3_mode),
    .fbit_stb(fbit_stb), .fbit_err(fbit_err),
    .mframe_stb(mframe_stb), .mframe_err(mframe_err),
    .fas_stb(fas_stb), .fas_err(fas_err),
    .reframe_done(reframe_done), .oof(oof), .reframe_req(reframe_req)
  );

  // entry: {mode, kind(0=F,1=M,2=FAS,3=done only), err, exp_oof, exp_req}
  localparam logic [5:0] VEC [36] = '{
    6'b0_00_1_00, 6'b0_00_0_00, 6'b0_00_1_00, 6'b0_00_0_00, 6'b0_00_1_11,
    6'b0_11_0_00,
    6'b0_01_1_00, 6'b0_01_0_00, 6'b0_01_1_11,
    6'b0_11_0_00,
    6'b0_01_1_00, 6'b0_01_0_00, 6'b0_01_0_00, 6'b0_01_1_00, 6'b0_01_1_11,
    6'b0_11_0_00,
    6'b0_10_1_00, 6'b0_10_1_00, 6'b0_10_1_00, 6'b0_10_1_00,
    6'b1_10_1_00, 6'b1_10_1_00, 6'b1_10_1_00, 6'b1_10_0_00,
    6'b1_10_1_00, 6'b1_10_1_00, 6'b1_10_1_00, 6'b1_10_1_11,
    6'b1_00_1_10,
    6'b1_11_0_00,
    6'b1_00_1_00, 6'b1_00_1_00, 6'b1_00_1_00, 6'b1_01_1_00, 6'b1_01_1_00,
    6'b1_11_0_00
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic op(input logic m, input logic [1:0] k, input logic e, input logic d);
    @(negedge clk);
    e3_mode      = m;
    fbit_stb     = (k == 2'd0); fbit_err   = e;
    mframe_stb   = (k == 2'd1); mframe_err = e;
    fas_stb      = (k == 2'd2); fas_err    = e;
    reframe_done = d | (k == 2'd3);
    @(negedge clk);
    fbit_stb = 1'b0; mframe_stb = 1'b0; fas_stb = 1'b0; reframe_done = 1'b0;
    fbit_err = 1'b0; mframe_err = 1'b0; fas_err = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 oof in reset", int'(oof), 0);
    chk("R8 req in reset", int'(reframe_req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 oof after reset", int'(oof), 0);

    for (int i = 0; i < 36; i++) begin
      op(VEC[i][5], VEC[i][4:3], VEC[i][2], 1'b0);
      chk($sformatf("R1/R2/R3/R6/R7 vec%0d oof", i), int'(oof), int'(VEC[i][1]));
      chk($sformatf("R4 vec%0d req", i), int'(reframe_req), int'(VEC[i][0]));
    end

    // R1 window edge: 3 errors spanning exactly 16 strobes
    op(0, 0, 1, 0);
    for (int i = 0; i < 13; i++) op(0, 0, 0, 0);
    op(0, 0, 1, 0);
    chk("R1 two in window", int'(oof), 0);
    op(0, 0, 1, 0);
    chk("R1 three within 16", int'(oof), 1);
    chk("R4 req at declare", int'(reframe_req), 1);
    @(negedge clk);
    chk("R4 req one cycle", int'(reframe_req), 0);
    // R5 hold and no further request
    repeat (4) @(negedge clk);
    chk("R5 oof held idle", int'(oof), 1);
    op(0, 0, 1, 0);
    chk("R5 no new req", int'(reframe_req), 0);
    op(0, 1, 1, 0);
    op(0, 1, 1, 0);
    chk("R5 no req on M hit", int'(reframe_req), 0);
    chk("R5 still oof", int'(oof), 1);
    op(0, 3, 0, 0);
    chk("R6 done clears", int'(oof), 0);

    // R1 oldest error slides out after 17 strobes
    op(0, 0, 1, 0);
    for (int i = 0; i < 14; i++) op(0, 0, 0, 0);
    op(0, 0, 1, 0);
    op(0, 0, 1, 0);
    chk("R1 oldest slid out", int'(oof), 0);
    op(0, 3, 0, 0);

    // R6 collision: done with an error strobe in the same cycle
    op(0, 0, 1, 0);
    op(0, 0, 1, 0);
    op(0, 0, 1, 1);
    chk("R6 done wins collision", int'(oof), 0);
    chk("R6 no req collision", int'(reframe_req), 0);
    op(0, 0, 1, 0);
    op(0, 0, 1, 0);
    chk("R6 history emptied", int'(oof), 0);
    op(0, 0, 1, 0);
    chk("R6 third error declares", int'(oof), 1);
    chk("R4 req after collision", int'(reframe_req), 1);
    op(0, 3, 0, 0);

    // R3 run restarts on a good word, exactly at the 4th error
    for (int i = 0; i < 3; i++) op(1, 2, 1, 0);
    op(1, 2, 0, 0);
    op(1, 2, 1, 0);
    chk("R3 restart after good", int'(oof), 0);
    op(1, 2, 1, 0); op(1, 2, 1, 0);
    chk("R3 three in run", int'(oof), 0);
    op(1, 2, 1, 0);
    chk("R3 fourth declares", int'(oof), 1);

    // R8 reset mid-episode
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R8 reset clears oof", int'(oof), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule